// File: doc/BRIEF.md
# MDIO Management Frame Master (Clause 22 / Clause 45)

This block lets software reach the management registers of Ethernet PHYs through the two-wire MDC/MDIO bus. Software loads an operation word, a register address and a data value through a small 32-bit register port. It then writes 1 to the control word. The block sends exactly one management frame on the bus. Software polls the control word until it reads 0. For a read, it then collects the returned 16 bits from the data word.

A single engine handles both frame families. The clause bit in the operation word chooses between them. A Clause 22 frame carries the register number directly. A Clause 45 access takes two frames: an address frame, which carries the address word, then a write or read frame. Software issues the two frames in turn. Everything the frame needs is captured when it starts, so later register writes cannot corrupt it.

The engine is a four-state machine:
- `S_IDLE`: waits for a start.
- `S_DRIVE`: MDC is low. A new bit is presented on MDIO.
- `S_SAMPLE`: MDC is high. Read data is sampled on entry.
- `S_FINISH`: a single cycle that hands read data to the register file.

Its transitions are:
- IDLE→DRIVE on an accepted start.
- DRIVE→SAMPLE after half an MDC period.
- SAMPLE→DRIVE after half an MDC period while bits remain.
- SAMPLE→FINISH after the 64th bit.
- FINISH→IDLE unconditionally.

Top module: `mdio_master`

## Requirements
- R1: After reset, MDC and MDIO output-enable are low, the control word reads 0, and the operation, address and data words read 0.
- R2: Writing a value with bit 0 set to the control word (offset 0) while idle starts a frame. Bit 0 of the control word reads 1 from the next cycle and for 64*CLK_DIV+1 cycles in total, then reads 0.
- R3: MDC has a period of CLK_DIV system clocks during a frame. Each bit begins with the low half. MDC stays low while idle.
- R4: A frame is sent MSB first, in this order:
  - 32 ones.
  - The start field: 01 for Clause 22, 00 for Clause 45.
  - The 2-bit opcode from operation-word bits [17:16].
  - The 5-bit port address from bits [9:5].
  - A 5-bit second field.
  - A 2-bit turnaround.
  - 16 data bits.

  Bit 20 of the operation word (offset 1) selects Clause 45 when set.
- R5: The second field is operation-word bits [4:0] for Clause 22 and bits [14:10] (the device) for Clause 45.
- R6: A Clause 45 frame with opcode 00 carries the low 16 bits of the address word (offset 2) as its data field.
- R7: A frame whose opcode bit 1 is clear drives turnaround 10, then the 16-bit data word (offset 3), with output-enable high for the whole frame.
- R8: A frame whose opcode bit 1 is set is a read:
  - Output-enable is low for the turnaround and data bits.
  - The data bits are sampled from MDIO input on each MDC rising edge.
  - The 16 sampled bits replace the data word when the frame ends.
- R9: MDIO output and output-enable change only while MDC is low, never during its high half.
- R10: A start written while a frame is running is ignored. No second frame follows.
- R11: Writes to the operation, address or data words during a frame do not alter the bits sent. A software write to the data word during a write frame is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | 2 | Word offset: 0 control, 1 operation, 2 address, 3 data |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable |
| mdio_i | input | 1 | MDIO input value |

## Verification
The bench drives all five frame kinds and compares MDC, output-enable, the driven bit and the busy flag to a behavioural model on every clock. It also plays a PHY that answers reads.

- Turnaround release: a design that releases the bus one bit late would show output-enable high at bit 46.
- Sampling edge: sampling on the wrong MDC edge would capture a shifted read word.
- Second field: mixing up the Clause 22 register field with the Clause 45 device field would corrupt bits 41 to 45.
- Writes during a frame: a second start and a data-word write are injected mid-frame. A design that does not latch at start would change the data bits on the wire, or would run a second frame and show the busy flag set after completion.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

    localparam int FRAME_BITS  = 64;
    localparam int RELEASE_IDX = 46;   // first turnaround bit
    localparam int DATA_IDX    = 48;   // first data bit

    localparam logic [1:0] OFS_CTRL = 2'd0;
    localparam logic [1:0] OFS_OP   = 2'd1;
    localparam logic [1:0] OFS_ADDR = 2'd2;
    localparam logic [1:0] OFS_DATA = 2'd3;

    typedef enum logic [1:0] {
        S_IDLE,
        S_DRIVE,
        S_SAMPLE,
        S_FINISH
    } eng_state_e;

    // Assemble the serial image of one management frame, MSB sent first.
    function automatic logic [FRAME_BITS-1:0] build_frame(
        input logic [31:0] op_word,
        input logic [15:0] addr_word,
        input logic [15:0] data_word
    );
        logic       is_c45;
        logic [1:0] opc;
        logic [1:0] st;
        logic [4:0] fld2;
        logic [15:0] payload;
        is_c45  = op_word[20];
        opc     = op_word[17:16];
        st      = is_c45 ? 2'b00 : 2'b01;
        fld2    = is_c45 ? op_word[14:10] : op_word[4:0];
        payload = (is_c45 && opc == 2'b00) ? addr_word : data_word;
        return {32'hFFFF_FFFF, st, opc, op_word[9:5], fld2, 2'b10, payload};
    endfunction

endpackage

// File: rtl/mdio_regfile.sv
module mdio_regfile
    import mdio_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [1:0]            reg_addr,
    input  logic                  reg_we,
    input  logic [31:0]           reg_wdata,
    output logic [31:0]           reg_rdata,
    input  logic                  busy_i,
    input  logic                  rx_valid_i,
    input  logic [15:0]           rx_data_i,
    output logic                  start_o,
    output logic                  rd_o,
    output logic [FRAME_BITS-1:0] frame_o
);

    logic [31:0] op_q;
    logic [15:0] addr_q;
    logic [15:0] data_q;

    assign start_o = reg_we && (reg_addr == OFS_CTRL) && reg_wdata[0] && !busy_i;
    assign rd_o    = op_q[17];
    assign frame_o = build_frame(op_q, addr_q, data_q);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_q   <= '0;
            addr_q <= '0;
            data_q <= '0;
        end else begin
            if (reg_we && reg_addr == OFS_OP)   op_q   <= reg_wdata;
            if (reg_we && reg_addr == OFS_ADDR) addr_q <= reg_wdata[15:0];
            if (rx_valid_i)                     data_q <= rx_data_i;
            else if (reg_we && reg_addr == OFS_DATA) data_q <= reg_wdata[15:0];
        end
    end

    always_comb begin
        unique case (reg_addr)
            OFS_CTRL: reg_rdata = {31'd0, busy_i};
            OFS_OP:   reg_rdata = op_q;
            OFS_ADDR: reg_rdata = {16'd0, addr_q};
            OFS_DATA: reg_rdata = {16'd0, data_q};
            default:  reg_rdata = '0;
        endcase
    end

    // R8: returned read data lands in the data word one cycle after hand-off
    p_capture_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid_i |=> data_q == $past(rx_data_i));

endmodule

// File: rtl/mdio_frame_engine.sv
module mdio_frame_engine
    import mdio_pkg::*;
#(
    parameter int CLK_DIV = 64
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start_i,
    input  logic                  rd_i,
    input  logic [FRAME_BITS-1:0] frame_i,
    input  logic                  mdio_i,
    output logic                  busy_o,
    output logic                  mdc_o,
    output logic                  mdio_o,
    output logic                  mdio_oe_o,
    output logic                  rx_valid_o,
    output logic [15:0]           rx_data_o
);

    localparam int HALF = CLK_DIV / 2;
    localparam int CW   = $clog2(HALF) + 1;
    localparam logic [CW-1:0] HALF_LAST = CW'(HALF - 1);
    localparam logic [5:0]    LAST_IDX  = 6'(FRAME_BITS - 1);

    eng_state_e state_q, state_d;
    logic [CW-1:0]         cnt_q;
    logic [5:0]            idx_q;
    logic [FRAME_BITS-1:0] tx_q;
    logic [15:0]           rx_q;
    logic                  rd_q;
    logic                  half_done;

    assign half_done = (cnt_q == HALF_LAST);

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:   if (start_i) state_d = S_DRIVE;
            S_DRIVE:  if (half_done) state_d = S_SAMPLE;
            S_SAMPLE: if (half_done) state_d = (idx_q == LAST_IDX) ? S_FINISH : S_DRIVE;
            S_FINISH: state_d = S_IDLE;
            default:  state_d = S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            idx_q <= '0;
            tx_q  <= '0;
            rx_q  <= '0;
            rd_q  <= 1'b0;
        end else begin
            unique case (state_q)
                S_IDLE: begin
                    if (start_i) begin
                        tx_q  <= frame_i;
                        rd_q  <= rd_i;
                        idx_q <= '0;
                        cnt_q <= '0;
                        rx_q  <= '0;
                    end
                end
                S_DRIVE: begin
                    if (half_done) begin
                        cnt_q <= '0;
                        if (rd_q && idx_q >= 6'(DATA_IDX))
                            rx_q <= {rx_q[14:0], mdio_i};
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                S_SAMPLE: begin
                    if (half_done) begin
                        cnt_q <= '0;
                        if (idx_q != LAST_IDX) begin
                            idx_q <= idx_q + 1'b1;
                            tx_q  <= {tx_q[FRAME_BITS-2:0], 1'b0};
                        end
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                S_FINISH: ;
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        busy_o     = (state_q != S_IDLE);
        mdc_o      = (state_q == S_SAMPLE);
        mdio_o     = tx_q[FRAME_BITS-1];
        mdio_oe_o  = (state_q == S_DRIVE || state_q == S_SAMPLE)
                     && !(rd_q && idx_q >= 6'(RELEASE_IDX));
        rx_valid_o = (state_q == S_FINISH) && rd_q;
        rx_data_o  = rx_q;
    end

    // R1: nothing moves on the bus while idle
    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (!mdc_o && !mdio_oe_o));
    // R9: bus value holds through the MDC high half
    p_stable_high_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (mdc_o && $past(mdc_o)) |-> ($stable(mdio_o) && $stable(mdio_oe_o)));
    // R10: the register file offers a start only when the engine is idle
    p_start_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |-> !busy_o);
    // R2: completion follows the high half of the final bit
    p_finish_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_FINISH) |-> ($past(mdc_o) && $past(idx_q) == LAST_IDX));

endmodule

// File: rtl/mdio_master.sv
module mdio_master
    import mdio_pkg::*;
#(
    parameter int CLK_DIV = 64
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [1:0]  reg_addr,
    input  logic        reg_we,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        mdc,
    output logic        mdio_o,
    output logic        mdio_oe,
    input  logic        mdio_i
);

    logic                  busy;
    logic                  start;
    logic                  rd;
    logic                  rx_valid;
    logic [15:0]           rx_data;
    logic [FRAME_BITS-1:0] frame;

    mdio_regfile u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .reg_addr   (reg_addr),
        .reg_we     (reg_we),
        .reg_wdata  (reg_wdata),
        .reg_rdata  (reg_rdata),
        .busy_i     (busy),
        .rx_valid_i (rx_valid),
        .rx_data_i  (rx_data),
        .start_o    (start),
        .rd_o       (rd),
        .frame_o    (frame)
    );

    mdio_frame_engine #(.CLK_DIV(CLK_DIV)) u_engine (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start),
        .rd_i       (rd),
        .frame_i    (frame),
        .mdio_i     (mdio_i),
        .busy_o     (busy),
        .mdc_o      (mdc),
        .mdio_o     (mdio_o),
        .mdio_oe_o  (mdio_oe),
        .rx_valid_o (rx_valid),
        .rx_data_o  (rx_data)
    );

endmodule

// File: tb/mdio_master_tb.sv
module mdio_master_tb;

    localparam int CLK_PERIOD = 10;
    localparam int DIV        = 8;
    localparam int HALF       = DIV / 2;
    localparam int NBITS      = 64;
    localparam int RUN_CYC    = NBITS * DIV;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic        reg_we = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        mdc, mdio_o, mdio_oe;
    logic        mdio_i = 1'b1;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mdio_master #(.CLK_DIV(DIV)) u_dut (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mdc(mdc),
        .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic reg_write(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_we = 1'b1; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0; reg_addr = 2'd0;
    endtask

    function automatic logic [31:0] op_word(input bit c45, input logic [1:0] opc,
                                            input logic [4:0] port, input logic [4:0] f2);
        logic [31:0] w = '0;
        w[20] = c45; w[17:16] = opc; w[9:5] = port;
        if (c45) w[14:10] = f2; else w[4:0] = f2;
        return w;
    endfunction

    // Reference frame image built field by field from R4 to R7
    function automatic logic [63:0] ref_frame(input bit c45, input logic [1:0] opc,
                                              input logic [4:0] port, input logic [4:0] f2,
                                              input logic [15:0] dat);
        logic [63:0] f;
        logic [1:0]  ta = 2'b10;
        f = '1;
        for (int i = 0; i < 2; i++) f[63-32-i] = c45 ? 1'b0 : (i == 1);
        for (int i = 0; i < 2; i++) f[63-34-i] = opc[1-i];
        for (int i = 0; i < 5; i++) f[63-36-i] = port[4-i];
        for (int i = 0; i < 5; i++) f[63-41-i] = f2[4-i];
        for (int i = 0; i < 2; i++) f[63-46-i] = ta[1-i];
        for (int i = 0; i < 16; i++) f[63-48-i] = dat[15-i];
        return f;
    endfunction

    // Start one frame and compare against the model on every clock.
    task automatic run_frame(input logic [63:0] exp_frame, input bit rd,
                             input logic [15:0] resp, input bit inject,
                             input logic [15:0] exp_data, input string tag);
        reg_write(2'd0, 32'h1);   // start edge precedes this negedge: t = 0
        for (int t = 0; t <= RUN_CYC; t++) begin
            int  idx;
            bit  running, e_mdc, e_oe;
            if (t > 0) @(negedge clk);
            idx     = t / DIV;
            running = (t < RUN_CYC);
            e_mdc   = running && ((t / HALF) % 2 == 1);
            e_oe    = running && !(rd && idx >= 46);
            if (!reg_we) check("R2 busy", reg_rdata, 32'h1);
            check("R3 mdc", {31'd0, mdc}, {31'd0, e_mdc});
            check(rd ? "R8 oe" : "R7 oe", {31'd0, mdio_oe}, {31'd0, e_oe});
            if (e_oe) check(e_mdc ? "R9 bit" : tag, {31'd0, mdio_o}, {31'd0, exp_frame[63-idx]});
            mdio_i = (running && rd && idx >= 48) ? resp[15-(idx-48)] : 1'b1;
            if (inject) begin
                // R10 / R11: restart and register rewrites mid-frame
                if (t == 100) begin reg_we = 1'b1; reg_addr = 2'd0; reg_wdata = 32'h1; end
                if (t == 101) begin reg_addr = 2'd3; reg_wdata = 32'hDEAD; end
                if (t == 102) begin reg_addr = 2'd1; reg_wdata = 32'h0; end
                if (t == 103) begin reg_addr = 2'd2; reg_wdata = 32'h0; end
                if (t == 104) begin reg_we = 1'b0; reg_addr = 2'd0; end
            end
        end
        mdio_i = 1'b1;
        for (int k = 0; k < 2 * DIV; k++) begin
            @(negedge clk);
            check("R10 idle after frame", reg_rdata, 32'h0);
            check("R10 mdc idle", {31'd0, mdc}, 32'h0);
        end
        reg_addr = 2'd3;
        #1 check(rd ? "R8 data" : "R11 data", reg_rdata, {16'd0, exp_data});
        reg_addr = 2'd0;
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check("R1 mdc", {31'd0, mdc}, 32'h0);
        check("R1 oe", {31'd0, mdio_oe}, 32'h0);
        for (int a = 0; a < 4; a++) begin
            reg_addr = 2'(a);
            #1 check("R1 reg", reg_rdata, 32'h0);
        end
        reg_addr = 2'd0;

        // R4 R5 R7: Clause 22 write
        reg_write(2'd1, op_word(1'b0, 2'b01, 5'h03, 5'h11));
        reg_write(2'd3, 32'hA5C3);
        run_frame(ref_frame(1'b0, 2'b01, 5'h03, 5'h11, 16'hA5C3), 1'b0, 16'h0, 1'b0,
                  16'hA5C3, "R4 R5 R7 c22 write");

        // R8: Clause 22 read
        reg_write(2'd1, op_word(1'b0, 2'b10, 5'h1F, 5'h02));
        run_frame(ref_frame(1'b0, 2'b10, 5'h1F, 5'h02, 16'h0), 1'b1, 16'h1234, 1'b0,
                  16'h1234, "R4 R8 c22 read");

        // R6: Clause 45 address frame, data word untouched
        reg_write(2'd1, op_word(1'b1, 2'b00, 5'h05, 5'h01));
        reg_write(2'd2, 32'h9002);
        run_frame(ref_frame(1'b1, 2'b00, 5'h05, 5'h01, 16'h9002), 1'b0, 16'h0, 1'b0,
                  16'h1234, "R4 R5 R6 c45 address");

        // R11 R10: Clause 45 write with mid-frame rewrites and restart
        reg_write(2'd1, op_word(1'b1, 2'b01, 5'h05, 5'h01));
        reg_write(2'd3, 32'h0F0F);
        run_frame(ref_frame(1'b1, 2'b01, 5'h05, 5'h01, 16'h0F0F), 1'b0, 16'h0, 1'b1,
                  16'hDEAD, "R7 R11 c45 write");

        // R8: Clause 45 read
        reg_write(2'd1, op_word(1'b1, 2'b11, 5'h0A, 5'h1E));
        run_frame(ref_frame(1'b1, 2'b11, 5'h0A, 5'h1E, 16'h0), 1'b1, 16'hBEEF, 1'b0,
                  16'hBEEF, "R4 R8 c45 read");

        finished = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule